// File: doc/BRIEF.md
# Instruction-Boundary Service Arbiter

This block decides, each time a control unit finishes the microcode routine of an instruction, what happens next: fetch and start the next instruction, enter a hold state, or begin interrupt handling. Requests arrive on two active-low inputs, and the arbiter looks at them only when the instruction-complete strobe is high. It never acts on them while an instruction is still running. A hold request outranks an interrupt request. When a hold ends, exactly one instruction runs before an interrupt that is still pending is taken. The exception is a second hold that arrives before that instruction completes: that hold is again served first.

When the chosen action is an instruction fetch, the arbiter also forms the first microcode address of the new instruction. It places a fixed constant in the upper bits and the opcode from the second pipeline register in the lower bits. All outputs are registered. A decision appears one cycle after the clock edge at which the strobe, or the hold release, is sampled.

Top module: `boundary_svc_arb`

## Requirements
- R1: After reset, `action_vld_o` is 0, `hold_active_o` is 0, `action_o` is 2'b00 and `uaddr_o` is 0.
- R2: The request inputs have no effect when `instr_done_i` is low. With `irq_ni` or `hold_ni` low and no completion strobe, `action_vld_o` stays 0.
- R3: At a completion strobe with both requests inactive (high), the next cycle shows `action_vld_o`=1 and `action_o`=2'b00 (fetch). `action_vld_o` is a single-cycle pulse.
- R4: At a completion strobe with `irq_ni` low, `hold_ni` high and no post-hold instruction in progress, the next cycle shows `action_o`=2'b10 (interrupt).
- R5: At a completion strobe with `hold_ni` low, the next cycle shows `action_o`=2'b01 (hold) and `hold_active_o`=1, whatever the state of `irq_ni`.
- R6: While `hold_active_o` is 1 and `hold_ni` stays low, `hold_active_o` stays 1 and `action_vld_o` stays 0. Completion strobes have no effect during this time.
- R7: On the first sampled edge with `hold_ni` high while in hold, the next cycle shows `hold_active_o`=0 and `action_vld_o`=1 with `action_o`=2'b00. The fetch address is formed from the opcode present at that edge.
- R8: At the first completion strobe after a hold release, a low `irq_ni` is not served: the action is fetch. At the completion strobe after that one, the interrupt is served.
- R9: If `hold_ni` is low at the first completion strobe after a hold release, the action is hold again.
- R10: Whenever a fetch is issued, `uaddr_o` equals {UADDR_BASE, opcode} as sampled at the deciding edge. UADDR_BASE is a 4-bit constant in bits 11:8 (default 4'hC), and the 8-bit opcode is in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_done_i | input | 1 | Instruction microcode routine complete strobe |
| irq_ni | input | 1 | Interrupt request, active low |
| hold_ni | input | 1 | Hold request, active low |
| opcode_i | input | OPC_W | Opcode from the second pipeline register |
| action_vld_o | output | 1 | One-cycle pulse: a new action was selected |
| action_o | output | 2 | 00 fetch, 01 hold, 10 interrupt |
| hold_active_o | output | 1 | Control unit is in the hold state |
| uaddr_o | output | BASE_W+OPC_W | Starting microcode address of the fetched instruction |

## Verification
Assertions check the following on every cycle:
- A hold at a boundary always wins.
- Nothing is issued while a hold persists.
- The post-hold instruction never yields to an interrupt.
- Every action pulse traces back to a strobe or a release.
- Each fetch address carries the sampled opcode.

Some behaviour can only be shown by the bench's scenarios, because it spans several decisions:
- The full two-boundary sequence of release, forced fetch and then the interrupt being served.
- A repeated hold during the post-hold instruction.
- The address layout at the extreme opcodes.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  typedef enum logic [1:0] {
    SVC_FETCH = 2'b00,
    SVC_HOLD  = 2'b01,
    SVC_IRQ   = 2'b10
  } svc_e;
endpackage

// File: rtl/bsa_decider.sv
module bsa_decider
  import bsa_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic irq_ni,
  input  logic hold_ni,
  output logic vld_o,
  output svc_e act_o,
  output logic hold_act_o,
  output logic load_o
);
  logic hold_q, post_q, vld_q;
  svc_e act_q, pick;
  logic boundary, release_w;

  assign boundary  = done_i && !hold_q;
  assign release_w = hold_q && hold_ni;

  // hold first; interrupt deferred for one instruction after hold release
  always_comb begin
    if (!hold_ni)                pick = SVC_HOLD;
    else if (!irq_ni && !post_q) pick = SVC_IRQ;
    else                         pick = SVC_FETCH;
  end

  assign load_o = (boundary && pick == SVC_FETCH) || release_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      act_q  <= SVC_FETCH;
      hold_q <= 1'b0;
      post_q <= 1'b0;
    end else begin
      vld_q <= boundary || release_w;
      if (boundary) begin
        act_q  <= pick;
        post_q <= 1'b0;
        if (pick == SVC_HOLD) hold_q <= 1'b1;
      end else if (release_w) begin
        act_q  <= SVC_FETCH;
        hold_q <= 1'b0;
        post_q <= 1'b1;
      end
    end
  end

  assign vld_o      = vld_q;
  assign act_o      = act_q;
  assign hold_act_o = hold_q;

  p_hold_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !hold_ni && !hold_q) |=> (vld_q && act_q == SVC_HOLD && hold_q));

  p_quiet_in_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && !hold_ni) |=> (!vld_q && hold_q));

  p_post_hold_fetch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_q && done_i && hold_ni && !hold_q) |=> (act_q == SVC_FETCH));

  p_only_at_boundary_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_i && !hold_q) |=> !vld_q);

  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && hold_ni) |=> (vld_q && !hold_q && act_q == SVC_FETCH));
endmodule

// File: rtl/bsa_uaddr.sv
module bsa_uaddr #(
  parameter int          OPC_W  = 8,
  parameter int          BASE_W = 4,
  parameter logic [3:0]  BASE   = 4'hC,
  localparam int         UA_W   = BASE_W + OPC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [OPC_W-1:0] opcode_i,
  output logic [UA_W-1:0]  uaddr_o
);
  logic [BASE_W-1:0] base_w;
  logic [UA_W-1:0]   ua_q;

  generate
    if (BASE_W <= 4) begin : g_narrow
      assign base_w = BASE[BASE_W-1:0];
    end else begin : g_wide
      assign base_w = {{(BASE_W-4){1'b0}}, BASE};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ua_q <= '0;
    else if (load_i) ua_q <= {base_w, opcode_i};
  end

  assign uaddr_o = ua_q;
endmodule

// File: rtl/boundary_svc_arb.sv
module boundary_svc_arb
  import bsa_pkg::*;
#(
  parameter int         OPC_W      = 8,
  parameter int         BASE_W     = 4,
  parameter logic [3:0] UADDR_BASE = 4'hC,
  localparam int        UA_W       = BASE_W + OPC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             instr_done_i,
  input  logic             irq_ni,
  input  logic             hold_ni,
  input  logic [OPC_W-1:0] opcode_i,
  output logic             action_vld_o,
  output logic [1:0]       action_o,
  output logic             hold_active_o,
  output logic [UA_W-1:0]  uaddr_o
);
  svc_e act;
  logic load;

  bsa_decider u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (instr_done_i),
    .irq_ni     (irq_ni),
    .hold_ni    (hold_ni),
    .vld_o      (action_vld_o),
    .act_o      (act),
    .hold_act_o (hold_active_o),
    .load_o     (load)
  );

  bsa_uaddr #(.OPC_W(OPC_W), .BASE_W(BASE_W), .BASE(UADDR_BASE)) u_ua (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .opcode_i (opcode_i),
    .uaddr_o  (uaddr_o)
  );

  assign action_o = act;

  p_fetch_opcode_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_done_i && !hold_active_o && irq_ni && hold_ni)
      |=> (action_vld_o && action_o == 2'b00 && uaddr_o[OPC_W-1:0] == $past(opcode_i)));
endmodule

// File: tb/boundary_svc_arb_tb.sv
module boundary_svc_arb_tb;
  localparam time CYC = 20ns;
  logic clk = 1'b0, rst_n = 1'b0;
  logic done = 1'b0, irq_n = 1'b1, hold_n = 1'b1;
  logic [7:0] opc = 8'h00;
  logic vld, hact;
  logic [1:0] act;
  logic [11:0] ua;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CYC/2) clk = ~clk;

  boundary_svc_arb u_dut (
    .clk_i(clk), .rst_ni(rst_n), .instr_done_i(done), .irq_ni(irq_n),
    .hold_ni(hold_n), .opcode_i(opc), .action_vld_o(vld), .action_o(act),
    .hold_active_o(hact), .uaddr_o(ua)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // one cycle: drive at negedge, clock, then sample at the following negedge
  task automatic cyc(input logic d, input logic i, input logic h, input logic [7:0] o);
    done = d; irq_n = i; hold_n = h; opc = o;
    @(posedge clk);
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 vld", vld, 0);
    check("R1 hold", hact, 0);
    check("R1 act", act, 0);
    check("R1 uaddr", ua, 0);
  endtask

  task automatic t_no_sample();
    for (int k = 0; k < 3; k++) begin
      cyc(0, 0, 0, 8'h11);
      check("R2 no strobe vld", vld, 0);
      check("R2 no strobe hold", hact, 0);
    end
  endtask

  task automatic t_fetch();
    cyc(1, 1, 1, 8'h5A);
    check("R3 vld", vld, 1);
    check("R3 act", act, 2'b00);
    check("R10 uaddr", ua, 12'hC5A);
    cyc(0, 1, 1, 8'h00);
    check("R3 pulse", vld, 0);
    cyc(1, 1, 1, 8'hFF);
    check("R10 uaddr max", ua, 12'hCFF);
    cyc(1, 1, 1, 8'h00);
    check("R10 uaddr min", ua, 12'hC00);
  endtask

  task automatic t_irq();
    cyc(1, 0, 1, 8'h22);
    check("R4 vld", vld, 1);
    check("R4 act", act, 2'b10);
    check("R10 irq keeps uaddr", ua, 12'hC00);
  endtask

  task automatic t_hold_then_irq();
    cyc(1, 0, 0, 8'h44);
    check("R5 act", act, 2'b01);
    check("R5 hold", hact, 1);
    for (int k = 0; k < 3; k++) begin
      cyc(1, 0, 0, 8'h44);
      check("R6 vld", vld, 0);
      check("R6 hold", hact, 1);
    end
    cyc(0, 0, 1, 8'h33);
    check("R7 vld", vld, 1);
    check("R7 act", act, 2'b00);
    check("R7 hold clear", hact, 0);
    check("R7 uaddr", ua, 12'hC33);
    cyc(1, 0, 1, 8'h34);
    check("R8 deferred act", act, 2'b00);
    check("R8 uaddr", ua, 12'hC34);
    cyc(1, 0, 1, 8'h35);
    check("R8 served act", act, 2'b10);
  endtask

  task automatic t_rehold();
    cyc(1, 1, 0, 8'h01);
    check("R5 hold", hact, 1);
    cyc(0, 0, 1, 8'h02);
    check("R7 release", hact, 0);
    cyc(1, 0, 0, 8'h03);
    check("R9 act", act, 2'b01);
    check("R9 hold", hact, 1);
    cyc(0, 0, 1, 8'h04);
    check("R7 release again", act, 2'b00);
    cyc(1, 0, 1, 8'h05);
    check("R8 deferred again", act, 2'b00);
    cyc(1, 0, 1, 8'h06);
    check("R8 served again", act, 2'b10);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_sample();
    t_fetch();
    t_irq();
    t_hold_then_irq();
    t_rehold();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule